// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block turns the decisions of a fixed-frequency, trailing-edge PWM loop into two gate enables for a synchronous step-down stage: one for the high-side switch and one for the low-side switch. Each switching cycle begins with a one-clock cycle-start pulse. The pulse sets a PWM latch that turns the high side on. The latch clears when the ramp comparator raises its off request, and the low side conducts for the rest of the cycle. The comparator, the ramp and any analog dead-time trimming sit outside the block. Its inputs are the cycle-start pulse, the comparator off request, a flag telling that the soft-start level has passed its threshold, and a global enable.

Three rules shape the output on top of plain trailing-edge PWM:
- **Start-up lockout.** The low-side switch is held off after reset, and after every loss of enable, until the high side has actually been driven or the soft-start flag is seen. A pre-charged output is therefore never pulled down at start-up.
- **Minimum on-time.** Once driven, the high side stays on for a minimum number of system clocks, whatever the comparator asks.
- **Bootstrap refresh.** The block counts switching cycles in which the high side never turned off. When that count reaches the limit, the PWM latch is cleared halfway through the next cycle, so the low side gets a pulse of about half a period and the bootstrap capacitor is refreshed.

The two enables are never high together. A programmable number of system clocks, during which both are low, separates every hand-over between them.

Top module: `buck_gate_seq`

## Requirements
- R1: After reset, and after any clock edge at which `en` is low, `ls_on` stays low until `hs_on` has been high or `ss_high` has been sampled high.
- R2: A cycle-start pulse with `en` high sets the PWM latch. `hs_on` then rises once the dead time has passed. After the edge that samples `pwm_off` high, provided the minimum on-time is met, `hs_on` falls and stays low until the next cycle-start pulse.
- R3: Every high pulse on `hs_on` that is not cut short by `en` going low lasts at least `MIN_ON_CLKS` clocks, even when `pwm_off` is already high when the cycle starts.
- R4: Suppose the latch is still set at `MAX_FULL_CYCLES` consecutive cycle-start pulses, meaning that many full cycles have passed without a turn-off. In the following cycle the latch is cleared `PERIOD_CLKS/2` clocks after its cycle-start pulse, and `ls_on` rises once within that cycle.
- R5: The count of full-duty cycles returns to zero whenever the latch is cleared inside a cycle. A partial cycle therefore restarts the count toward the R4 limit.
- R6: `hs_on` and `ls_on` are never high at the same time.
- R7: Between the fall of either enable and the rise of either enable, both stay low for at least `DEAD_CLKS` clock edges.
- R8: While `en` is low, both enables are low in the same instant, without waiting for a clock edge, and cycle-start pulses have no effect.
- R9: During and just after reset, both `hs_on` and `ls_on` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable; low forces both gates off and re-arms the lockout |
| cyc_start | input | 1 | One-clock pulse at the start of each switching cycle |
| pwm_off | input | 1 | Comparator request to end the high-side pulse |
| ss_high | input | 1 | Soft-start level is above its threshold |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The hardest state to reach from the ports is the bootstrap-refresh point. Reaching it takes an unbroken run of full-duty cycles, and the refresh must land exactly at the half-period mark of the cycle that follows the run. The stimulus table gets there by holding `pwm_off` low through twenty consecutive periods and then counting `ls_on` rises in the next period. It then runs fifteen full cycles, one partial cycle and fifteen more full cycles. No refresh must appear in that sequence, which shows that a turn-off restarts the count. Directed steps afterwards drop `en` while the high side is on, and hold `pwm_off` high with no cycle start so that only the lockout decides the low side.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic [1:0] {
      GS_IDLE = 2'd0,
      GS_HIGH = 2'd1,
      GS_LOW  = 2'd2
   } gate_st_e;

   // Width of a counter that must hold values 0..maxval.
   function automatic int unsigned cnt_w(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/bseq_pwm_latch.sv
module bseq_pwm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cyc_start,
   input  logic pwm_off,
   input  logic min_met,
   input  logic force_off,
   output logic latch_q,
   output logic clear_evt
);
   logic set_c;

   // A new cycle wins over any clear request on the same edge.
   always_comb begin
      set_c     = en & cyc_start;
      clear_evt = en & latch_q & ~set_c & (force_off | (pwm_off & min_met));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         latch_q <= 1'b0;
      else if (!en)       latch_q <= 1'b0;
      else if (set_c)     latch_q <= 1'b1;
      else if (clear_evt) latch_q <= 1'b0;
   end
endmodule

// File: rtl/bseq_fullduty_mon.sv
module bseq_fullduty_mon #(
   parameter int unsigned PERIOD_CLKS     = 139,
   parameter int unsigned MAX_FULL_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cyc_start,
   input  logic latch_q,
   input  logic clear_evt,
   output logic force_off
);
   import bseq_pkg::*;

   localparam int unsigned POS_W = cnt_w(PERIOD_CLKS);
   localparam int unsigned RUN_W = cnt_w(MAX_FULL_CYCLES);
   localparam logic [POS_W-1:0] POS_MAX = '1;
   localparam logic [POS_W-1:0] MID_AT  = POS_W'(PERIOD_CLKS / 2 - 1);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_FULL_CYCLES);

   logic [POS_W-1:0] pos_q;
   logic [RUN_W-1:0] run_q;
   logic             mid_hit;

   // Clocks since the last cycle start; parked at the top until one arrives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pos_q <= POS_MAX;
      else if (en && cyc_start)  pos_q <= '0;
      else if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
   end

   assign mid_hit = en & (pos_q == MID_AT);

   // Cycles that started with the latch still set, without a turn-off since.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     run_q <= '0;
      else if (!en || clear_evt)                      run_q <= '0;
      else if (cyc_start && latch_q && run_q != RUN_LIM) run_q <= run_q + 1'b1;
   end

   assign force_off = mid_hit & (run_q == RUN_LIM);
endmodule

// File: rtl/bseq_gate_stage.sv
module bseq_gate_stage #(
   parameter int unsigned DEAD_CLKS   = 3,
   parameter int unsigned MIN_ON_CLKS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic latch_q,
   input  logic ss_high,
   output logic hs_on,
   output logic ls_on,
   output logic min_met
);
   import bseq_pkg::*;

   localparam int unsigned MW = cnt_w(MIN_ON_CLKS);
   localparam logic [MW-1:0] MIN_V  = MW'(MIN_ON_CLKS);
   localparam logic [MW-1:0] MIN_M1 = MW'(MIN_ON_CLKS - 1);

   gate_st_e       st_q, st_n;
   logic           armed_q;
   logic           dead_ok;
   logic           hs_req, ls_req;
   logic [MW-1:0]  hs_run_q;

   // Dead-time counter variant chosen by parameter.
   generate
      if (DEAD_CLKS == 0) begin : g_nodead
         assign dead_ok = 1'b1;
      end else begin : g_dead
         localparam int unsigned DW = cnt_w(DEAD_CLKS);
         localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CLKS);
         logic [DW-1:0] dcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       dcnt_q <= '0;
            else if (!en || st_q != GS_IDLE)  dcnt_q <= '0;
            else if (dcnt_q != DEAD_V)        dcnt_q <= dcnt_q + 1'b1;
         end
         assign dead_ok = (dcnt_q == DEAD_V);
      end
   endgenerate

   // Start-up lockout: cleared by a real high-side attempt or soft-start flag.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          armed_q <= 1'b1;
      else if (!en)                        armed_q <= 1'b1;
      else if (st_q == GS_HIGH || ss_high) armed_q <= 1'b0;
   end

   always_comb begin
      hs_req = en & latch_q;
      ls_req = en & ~latch_q & ~armed_q;
      st_n   = st_q;
      unique case (st_q)
         GS_IDLE: begin
            if (dead_ok) begin
               if (hs_req)      st_n = GS_HIGH;
               else if (ls_req) st_n = GS_LOW;
            end
         end
         GS_HIGH: if (!hs_req) st_n = GS_IDLE;
         GS_LOW:  if (!ls_req) st_n = GS_IDLE;
         default: st_n = GS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st_q <= GS_IDLE;
      else if (!en) st_q <= GS_IDLE;
      else          st_q <= st_n;
   end

   // Clocks the high side has been driven in the current pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hs_run_q <= '0;
      else if (st_q != GS_HIGH)  hs_run_q <= '0;
      else if (hs_run_q != MIN_V) hs_run_q <= hs_run_q + 1'b1;
   end

   assign min_met = (st_q == GS_HIGH) & (hs_run_q >= MIN_M1);
   assign hs_on   = en & (st_q == GS_HIGH);
   assign ls_on   = en & (st_q == GS_LOW);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
   parameter int unsigned PERIOD_CLKS     = 139,
   parameter int unsigned DEAD_CLKS       = 3,
   parameter int unsigned MIN_ON_CLKS     = 12,
   parameter int unsigned MAX_FULL_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cyc_start,
   input  logic pwm_off,
   input  logic ss_high,
   output logic hs_on,
   output logic ls_on
);
   localparam int unsigned HALF_CLKS = PERIOD_CLKS / 2;

   generate
      if (PERIOD_CLKS < 8) begin : g_bad_period
         $error("buck_gate_seq: PERIOD_CLKS must be at least 8");
      end
      if (MIN_ON_CLKS < 1) begin : g_bad_min
         $error("buck_gate_seq: MIN_ON_CLKS must be at least 1");
      end
      if (MAX_FULL_CYCLES < 1) begin : g_bad_max
         $error("buck_gate_seq: MAX_FULL_CYCLES must be at least 1");
      end
      if (MIN_ON_CLKS + DEAD_CLKS + 2 >= HALF_CLKS) begin : g_bad_fit
         $error("buck_gate_seq: minimum on-time plus dead time must fit in half a period");
      end
   endgenerate

   logic latch_q, clear_evt, force_off, min_met;

   bseq_pwm_latch u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cyc_start (cyc_start),
      .pwm_off   (pwm_off),
      .min_met   (min_met),
      .force_off (force_off),
      .latch_q   (latch_q),
      .clear_evt (clear_evt)
   );

   bseq_fullduty_mon #(
      .PERIOD_CLKS     (PERIOD_CLKS),
      .MAX_FULL_CYCLES (MAX_FULL_CYCLES)
   ) u_fullduty (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cyc_start (cyc_start),
      .latch_q   (latch_q),
      .clear_evt (clear_evt),
      .force_off (force_off)
   );

   bseq_gate_stage #(
      .DEAD_CLKS   (DEAD_CLKS),
      .MIN_ON_CLKS (MIN_ON_CLKS)
   ) u_gates (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .latch_q (latch_q),
      .ss_high (ss_high),
      .hs_on   (hs_on),
      .ls_on   (ls_on),
      .min_met (min_met)
   );
endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk #(
   parameter int unsigned PERIOD_CLKS     = 139,
   parameter int unsigned DEAD_CLKS       = 3,
   parameter int unsigned MIN_ON_CLKS     = 12,
   parameter int unsigned MAX_FULL_CYCLES = 20
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic ss_high,
   input logic hs_on,
   input logic ls_on
);
   localparam int unsigned RUN_LIM = (MAX_FULL_CYCLES + 1) * PERIOD_CLKS;
   localparam int unsigned LW      = $clog2(RUN_LIM + 2);
   localparam int unsigned QW      = $clog2(DEAD_CLKS + 2);

   logic [LW-1:0] hs_len_q;
   logic [QW-1:0] quiet_q;
   logic          armed_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          hs_len_q <= '0;
      else if (!hs_on)                     hs_len_q <= '0;
      else if (hs_len_q != LW'(RUN_LIM + 1)) hs_len_q <= hs_len_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          quiet_q <= '0;
      else if (hs_on || ls_on)             quiet_q <= '0;
      else if (quiet_q != QW'(DEAD_CLKS))  quiet_q <= quiet_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                armed_c <= 1'b1;
      else if (!en)              armed_c <= 1'b1;
      else if (hs_on || ss_high) armed_c <= 1'b0;
   end

   assert_lockout_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ls_on |-> !armed_c);

   assert_min_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hs_on) && en) |-> (hs_len_q >= LW'(MIN_ON_CLKS)));

   assert_max_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hs_len_q <= LW'(RUN_LIM));

   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on && ls_on));

   assert_dead_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_on) || $rose(ls_on)) |-> (quiet_q >= QW'(DEAD_CLKS)));

   assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!hs_on && !ls_on));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(
   .PERIOD_CLKS     (PERIOD_CLKS),
   .DEAD_CLKS       (DEAD_CLKS),
   .MIN_ON_CLKS     (MIN_ON_CLKS),
   .MAX_FULL_CYCLES (MAX_FULL_CYCLES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .ss_high (ss_high),
   .hs_on   (hs_on),
   .ls_on   (ls_on)
);

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;
   localparam int P     = 40;
   localparam int DEAD  = 2;
   localparam int MINON = 4;
   localparam int MAXF  = 20;
   localparam int NEVER = 255;
   localparam int NROWS = 8;
   // Stimulus table: off position, repeat count, expected ls rises, hs check mode
   // hs mode: 0 = trailing-edge range, 1 = minimum width, 2 = held on all cycle, 3 = forced refresh
   localparam int ROW_OFF [NROWS] = '{10, 0, 20, NEVER, NEVER, NEVER, 20, NEVER};
   localparam int ROW_REP [NROWS] = '{1, 1, 1, MAXF, 1, 15, 1, 15};
   localparam int ROW_LS  [NROWS] = '{1, 1, 1, 0, 1, 0, 1, 0};
   localparam int ROW_HSM [NROWS] = '{0, 1, 0, 2, 3, 2, 0, 2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic cyc_start = 1'b0;
   logic pwm_off = 1'b1;
   logic ss_high = 1'b0;
   logic hs_on, ls_on;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit prev_ls = 1'b0;
   bit prev_any = 1'b0;
   int quiet = 0;
   bit armed_m = 1'b1;
   int ovl_bad = 0;
   int gap_bad = 0;
   int lock_bad = 0;

   always #4 clk = ~clk;

   buck_gate_seq #(
      .PERIOD_CLKS     (P),
      .DEAD_CLKS       (DEAD),
      .MIN_ON_CLKS     (MINON),
      .MAX_FULL_CYCLES (MAXF)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cyc_start (cyc_start),
      .pwm_off   (pwm_off),
      .ss_high   (ss_high),
      .hs_on     (hs_on),
      .ls_on     (ls_on)
   );

   // Continuous monitor for R1, R6, R7, sampled away from the active edge.
   always begin
      @(negedge clk);
      #1;
      if (hs_on && ls_on) ovl_bad++;
      if ((hs_on || ls_on) && !prev_any && quiet < DEAD) gap_bad++;
      if (ls_on && armed_m) lock_bad++;
      if (!rst_n || !en) armed_m = 1'b1;
      else if (hs_on || ss_high) armed_m = 1'b0;
      if (hs_on || ls_on) quiet = 0;
      else quiet++;
      prev_any = hs_on || ls_on;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic string row_tag(input int r);
      case (r)
         1:       return "R3";
         3, 4:    return "R4";
         5, 6, 7: return "R5";
         default: return "R2";
      endcase
   endfunction

   task automatic run_cycle(input int off_pos, output int hs_clks, output int ls_clks,
                            output int hs_last, output int ls_rises);
      hs_clks = 0; ls_clks = 0; hs_last = 0; ls_rises = 0;
      for (int i = 0; i < P; i++) begin
         @(negedge clk);
         if (hs_on) hs_clks++;
         if (ls_on) ls_clks++;
         if (ls_on && !prev_ls) ls_rises++;
         prev_ls = ls_on;
         hs_last = hs_on;
         cyc_start = (i == 0);
         pwm_off   = (i >= off_pos);
      end
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R2: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int hc, lc, hl, lr, bad;
      // R9: reset state
      repeat (3) @(negedge clk);
      chk(!hs_on && !ls_on, "R9", "gates during reset", {hs_on, ls_on}, 0);
      rst_n = 1'b1;
      en = 1'b1;
      @(negedge clk);
      chk(!hs_on && !ls_on, "R9", "gates after reset", {hs_on, ls_on}, 0);
      // R1: no cycle yet, comparator says off, low side must stay locked out
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (ls_on) bad++;
      end
      chk(bad == 0, "R1", "ls before first high-side attempt", bad, 0);

      prev_ls = ls_on;
      for (int r = 0; r < NROWS; r++) begin
         for (int k = 0; k < ROW_REP[r]; k++) begin
            run_cycle(ROW_OFF[r], hc, lc, hl, lr);
            chk(lr == ROW_LS[r], row_tag(r), $sformatf("row %0d cycle %0d ls rises", r, k), lr, ROW_LS[r]);
            case (ROW_HSM[r])
               0: begin
                  chk(hc >= ROW_OFF[r] - DEAD - 3 && hc <= ROW_OFF[r] + 2, row_tag(r),
                      $sformatf("row %0d hs clocks", r), hc, ROW_OFF[r]);
                  chk(hl == 0, row_tag(r), $sformatf("row %0d hs off at cycle end", r), hl, 0);
               end
               1: begin
                  chk(hc >= MINON, "R3", "hs minimum width", hc, MINON);
                  chk(hl == 0, "R3", "hs off at cycle end", hl, 0);
               end
               2: chk(hl == 1, row_tag(r), $sformatf("row %0d hs held", r), hl, 1);
               default: chk(lc >= 1 && lc <= P / 2, "R4", "refresh ls clocks", lc, P / 2 - DEAD - 4);
            endcase
         end
      end

      // R8: drop enable while the high side is on
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         cyc_start = (i == 0);
         pwm_off = 1'b0;
      end
      chk(hs_on == 1'b1, "R8", "hs on before disable", hs_on, 1);
      en = 1'b0;
      #1;
      chk(!hs_on && !ls_on, "R8", "gates drop at once", {hs_on, ls_on}, 0);
      bad = 0;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (hs_on || ls_on) bad++;
         cyc_start = (i == 2);
      end
      chk(bad == 0, "R8", "cycle start ignored while disabled", bad, 0);

      // R1: re-armed lockout after enable returns
      pwm_off = 1'b1;
      en = 1'b1;
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (ls_on) bad++;
      end
      chk(bad == 0, "R1", "ls held off after re-enable", bad, 0);
      ss_high = 1'b1;
      bad = 0;
      for (int i = 0; i < DEAD + 6; i++) begin
         @(negedge clk);
         if (ls_on) bad++;
      end
      chk(bad > 0, "R1", "ls released by soft-start flag", bad, 1);

      repeat (2) @(negedge clk);
      chk(ovl_bad == 0, "R6", "overlap samples", ovl_bad, 0);
      chk(gap_bad == 0, "R7", "dead-time violations", gap_bad, 0);
      chk(lock_bad == 0, "R1", "ls while locked out", lock_bad, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule